// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block drives the two-wire station management bus of an Ethernet PHY: a management clock (MDC) and one bidirectional data line (MDIO). A host reaches it through a small 32-bit register port. The host programs a clock divider and sets an enable bit. It loads a payload for writes, then issues one access by writing an operation code, a PHY address and a register address together with a start bit. The controller then sends a complete Clause 22 frame on MDIO: a run of preamble ones, the start pattern, the opcode, both addresses, the turnaround and sixteen data bits. For a read it stops driving the line at the turnaround and shifts in the sixteen bits returned by the PHY.

The host learns that an access has finished by polling a ready flag in the control register, or by checking a sticky completion flag. Read results stay in a dedicated register until the next read finishes. MDC runs only while a frame is in flight and rests low at all other times.

The five registers sit at word offsets 0x00 (configuration), 0x04 (control and status), 0x08 (read result), 0x0C (write payload) and 0x10 (completion flag).

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and MDIO is not driven; writing zero to the configuration, read-result or write-payload register makes it read back zero.
- R2: Configuration bits [7:0] hold a divider D and bit 8 is the enable; while a frame runs, each MDC high and low phase lasts exactly D+1 system clocks.
- R3: Control bit 0 (ready) reads 1 when the controller is enabled and idle. Setting control bit 8 (start) while ready makes ready read 0 on the very next register read. Bit 8 always reads back 0. Ready returns to 1 once the frame ends.
- R4: A write (control bits [31:30] = 01, PHY address in bits [28:24], register address in bits [20:16]) sends 64 bits MSB first, one per MDC rising edge: 32 ones, 01, the opcode, the PHY address, the register address, 10, then the 16-bit payload. MDIO is driven for the whole frame.
- R5: A read (bits [31:30] = 10) sends the same first 46 bits and releases MDIO for the last 18. It samples MDIO on each of the last 16 MDC rising edges, MSB first, and shows that value in read-result bits [15:0] once ready is back.
- R6: A start with opcode 00 or 11 is ignored: ready stays 1, MDC does not toggle and the completion flag does not change.
- R7: A start written while a frame is in flight is ignored: the control fields read back unchanged and the running frame completes as first issued.
- R8: Bit 0 of the completion register is set when a frame ends. Writing 1 to it clears it, writing 0 leaves it set, and an accepted start clears it.
- R9: MDC stays low whenever no frame runs, and MDIO output changes only while MDC is low.
- R10: While the enable bit is 0, ready reads 0 and a start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrData | input | 32 | Register write data |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe; data valid next cycle |
| busRdData | output | 32 | Register read data |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value to drive |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the pad |

## Verification
The bench builds the block with its default parameters: an 8-bit divider and a 32-bit preamble, so every frame has its full length. It sweeps the divider over 0, 1, 2 and 5, so half-periods from a single clock up to six clocks appear. At each setting it alternates writes and reads with addresses and payloads computed from the loop indices, and it adds all-zero and all-one frames to reach the edges of every field. A PHY model in the bench records each bit at MDC rising edges and returns read data after falling edges. This exposes the turnaround release, the sampling point and the bit order directly.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  // register word indices (byte offset / 4)
  localparam logic [2:0] IDX_CFG  = 3'd0;
  localparam logic [2:0] IDX_CTRL = 3'd1;
  localparam logic [2:0] IDX_RDAT = 3'd2;
  localparam logic [2:0] IDX_WDAT = 3'd3;
  localparam logic [2:0] IDX_IRQ  = 3'd4;

  // bit positions the host relies on
  localparam int CFG_EN_BIT    = 8;
  localparam int CTL_START_BIT = 8;
  localparam int CTL_REG_LSB   = 16;
  localparam int CTL_PHY_LSB   = 24;
  localparam int CTL_OP_LSB    = 30;

  localparam int FLD_W  = 5;   // PHY / register address width
  localparam int DATA_W = 16;  // management data width
  localparam int BODY_W = 32;  // frame bits after the preamble

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // parallel-load the outgoing frame
    logic shift;    // advance to the next outgoing bit
    logic capture;  // sample MDIO into the receive shifter
    logic commit;   // copy received word into the result register
    logic clear;    // host cleared the result register
  } mdioStrb_t;

endpackage

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     divVal,
  input  logic                 clkRun,
  input  mdioStrb_t            strb,
  input  logic [PRE_LEN+BODY_W-1:0] frameWord,
  input  logic                 mdioIn,
  input  logic                 mdioOe,
  output logic                 tickRise,
  output logic                 tickFall,
  output logic                 mdc,
  output logic                 mdioOut,
  output logic [DATA_W-1:0]    rdHold
);

  localparam int FRAME_LEN = PRE_LEN + BODY_W;

  logic [DIV_W-1:0]     divCnt;
  logic                 mdcQ;
  logic [FRAME_LEN-1:0] txShift;
  logic [DATA_W-1:0]    rxShift;
  logic                 halfDone;

  // half-period divider: MDC toggles every divVal+1 clocks while running
  assign halfDone = clkRun && (divCnt == divVal);
  assign tickRise = halfDone && !mdcQ;
  assign tickFall = halfDone && mdcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (!clkRun) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (halfDone) begin
      divCnt <= '0;
      mdcQ   <= !mdcQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // outgoing frame, MSB first; ones fill in behind
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.load) begin
      txShift <= frameWord;
    end else if (strb.shift) begin
      txShift <= {txShift[FRAME_LEN-2:0], 1'b1};
    end
  end

  // incoming data, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdHold  <= '0;
    end else begin
      if (strb.capture) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strb.clear)       rdHold <= '0;
      else if (strb.commit) rdHold <= rxShift;
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = txShift[FRAME_LEN-1];

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN) !clkRun |=> !mdcQ); // R9
  AST_MDO_MOVES_LOW: assert property (@(posedge clk) disable iff (!rstN) !$stable(mdioOut) |-> !mdcQ); // R9
  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN) strb.capture |-> !mdioOe); // R5

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWrData,
  input  logic                 busWr,
  input  logic                 busRd,
  output logic [31:0]          busRdData,
  input  logic                 tickRise,
  input  logic                 tickFall,
  input  logic [DATA_W-1:0]    rdHold,
  output logic [DIV_W-1:0]     divVal,
  output logic                 clkRun,
  output mdioStrb_t            strb,
  output logic [PRE_LEN+BODY_W-1:0] frameWord,
  output logic                 mdioOe
);

  localparam int FRAME_LEN = PRE_LEN + BODY_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int IDXW      = ADDR_W - 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DATA_BIT = CNT_W'(PRE_LEN + 16);

  logic [IDXW-1:0]   idx;
  logic              selCfg, selCtl, selRdat, selWdat, selIrq;
  logic [DIV_W-1:0]  divQ;
  logic              enQ, busyQ, irqQ;
  logic [1:0]        opQ;
  logic [FLD_W-1:0]  phyQ, regQ;
  logic [DATA_W-1:0] wdQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [1:0]        wrOp;
  logic              opValid, ready, startAcc, isRead, doneEv;
  logic [1:0]        taBits;
  logic [DATA_W-1:0] dataBits;
  logic [31:0]       rdMux;
  logic              unusedBits;

  assign idx     = busAddr[ADDR_W-1:2];
  assign selCfg  = busWr && (idx == IDXW'(IDX_CFG));
  assign selCtl  = busWr && (idx == IDXW'(IDX_CTRL));
  assign selRdat = busWr && (idx == IDXW'(IDX_RDAT));
  assign selWdat = busWr && (idx == IDXW'(IDX_WDAT));
  assign selIrq  = busWr && (idx == IDXW'(IDX_IRQ));
  assign unusedBits = ^{busAddr[1:0], busWrData};

  assign wrOp     = busWrData[CTL_OP_LSB +: 2];
  assign opValid  = (wrOp == OP_WRITE) || (wrOp == OP_READ);
  assign ready    = enQ && !busyQ;
  assign startAcc = selCtl && busWrData[CTL_START_BIT] && ready && opValid;
  assign isRead   = (opQ == OP_READ);
  assign doneEv   = busyQ && tickFall && (bitCnt == LAST_BIT);

  // configuration, payload and completion flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= '0;
      enQ  <= 1'b0;
      wdQ  <= '0;
      irqQ <= 1'b0;
    end else begin
      if (selCfg) begin
        divQ <= busWrData[DIV_W-1:0];
        enQ  <= busWrData[CFG_EN_BIT];
      end
      if (selWdat) wdQ <= busWrData[DATA_W-1:0];
      if (doneEv)                         irqQ <= 1'b1;
      else if (startAcc)                  irqQ <= 1'b0;
      else if (selIrq && busWrData[0])    irqQ <= 1'b0;
    end
  end

  // control fields are frozen while a frame runs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ  <= '0;
      phyQ <= '0;
      regQ <= '0;
    end else if (selCtl && !busyQ) begin
      opQ  <= wrOp;
      phyQ <= busWrData[CTL_PHY_LSB +: FLD_W];
      regQ <= busWrData[CTL_REG_LSB +: FLD_W];
    end
  end

  // frame sequencer: one count per MDC falling edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      bitCnt <= '0;
    end else if (!enQ) begin
      busyQ  <= 1'b0;
      bitCnt <= '0;
    end else if (startAcc) begin
      busyQ  <= 1'b1;
      bitCnt <= '0;
    end else if (busyQ && tickFall) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) busyQ <= 1'b0;
    end
  end

  // outgoing frame assembled straight from the accepted control write
  always_comb begin
    taBits    = (wrOp == OP_WRITE) ? 2'b10 : 2'b11;
    dataBits  = (wrOp == OP_WRITE) ? wdQ : '1;
    frameWord = {{PRE_LEN{1'b1}}, 2'b01, wrOp,
                 busWrData[CTL_PHY_LSB +: FLD_W], busWrData[CTL_REG_LSB +: FLD_W],
                 taBits, dataBits};
  end

  always_comb begin
    strb.load    = startAcc;
    strb.shift   = busyQ && tickFall;
    strb.capture = busyQ && tickRise && isRead && (bitCnt >= DATA_BIT);
    strb.commit  = doneEv && isRead;
    strb.clear   = selRdat;
  end

  assign divVal = divQ;
  assign clkRun = busyQ;
  assign mdioOe = busyQ && (!isRead || (bitCnt < TA_BIT));

  // register readback, one cycle after the read strobe
  always_comb begin
    rdMux = '0;
    if (idx == IDXW'(IDX_CFG)) begin
      rdMux[DIV_W-1:0]  = divQ;
      rdMux[CFG_EN_BIT] = enQ;
    end else if (idx == IDXW'(IDX_CTRL)) begin
      rdMux[CTL_OP_LSB +: 2]      = opQ;
      rdMux[CTL_PHY_LSB +: FLD_W] = phyQ;
      rdMux[CTL_REG_LSB +: FLD_W] = regQ;
      rdMux[0]                    = ready;
    end else if (idx == IDXW'(IDX_RDAT)) begin
      rdMux[DATA_W-1:0] = rdHold;
    end else if (idx == IDXW'(IDX_WDAT)) begin
      rdMux[DATA_W-1:0] = wdQ;
    end else if (idx == IDXW'(IDX_IRQ)) begin
      rdMux[0] = irqQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdData <= '0;
    else if (busRd) busRdData <= rdMux;
  end

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN) (selCtl && busWrData[CTL_START_BIT] && enQ && !busyQ && opValid) |=> !ready); // R3
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rstN) (selCtl && busWrData[CTL_START_BIT] && ready && !opValid) |=> (ready && !clkRun)); // R6
  AST_BUSY_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN) (busyQ && selCtl) |=> ($stable(opQ) && $stable(phyQ) && $stable(regQ))); // R7
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN) (selIrq && busWrData[0] && !doneEv) |=> !irqQ); // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN) !enQ |=> !clkRun); // R10

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [31:0]       busRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int FRAME_LEN = PRE_LEN + BODY_W;

  mdioStrb_t             strb;
  logic [DIV_W-1:0]      divVal;
  logic                  clkRun, tickRise, tickFall;
  logic [FRAME_LEN-1:0]  frameWord;
  logic [DATA_W-1:0]     rdHold;

  mdio_mgmt_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData),
    .tickRise(tickRise), .tickFall(tickFall), .rdHold(rdHold),
    .divVal(divVal), .clkRun(clkRun), .strb(strb), .frameWord(frameWord),
    .mdioOe(mdioOe)
  );

  mdio_mgmt_dp #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_dp (
    .clk(clk), .rstN(rstN),
    .divVal(divVal), .clkRun(clkRun), .strb(strb), .frameWord(frameWord),
    .mdioIn(mdioIn), .mdioOe(mdioOe),
    .tickRise(tickRise), .tickFall(tickFall),
    .mdc(mdc), .mdioOut(mdioOut), .rdHold(rdHold)
  );

endmodule

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic        mdioIn = 1'b1;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe;

  int nChk = 0;
  int nFail = 0;

  // per-transfer monitor state, reset whenever xferId changes
  int xferId = 0;
  int riseId = 0, fallId = 0, measId = 0;
  int nRise = 0, nFall = 0;
  logic [63:0] gotFrame = '0, gotOe = '0;
  logic [15:0] phyRdVal = '0;
  int runLen = 0, minHalf = 0, maxHalf = 0, mdoBad = 0;
  bit seenTog = 0;
  logic prevMdc = 1'b0, prevMdo = 1'b0;

  always #4 clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model: record bits on rising MDC
  always @(posedge mdc) begin
    if (riseId != xferId) begin riseId = xferId; nRise = 0; end
    if (nRise < 64) begin
      gotFrame[63-nRise] = mdioOut;
      gotOe[63-nRise]    = mdioOe;
    end
    nRise++;
  end

  // PHY model: present read data after falling MDC
  always @(negedge mdc) begin
    if (fallId != xferId) begin fallId = xferId; nFall = 0; end
    nFall++;
    if (nFall >= 48 && nFall <= 63) mdioIn = phyRdVal[63-nFall];
    else mdioIn = 1'b1;
  end

  // half-period and MDIO-change monitor
  always @(negedge clk) begin
    if (measId != xferId) begin
      measId = xferId; seenTog = 0; minHalf = 1000; maxHalf = 0; mdoBad = 0;
    end
    if (mdc !== prevMdc) begin
      if (seenTog) begin
        if (runLen < minHalf) minHalf = runLen;
        if (runLen > maxHalf) maxHalf = runLen;
      end
      seenTog = 1;
      runLen = 1;
    end else begin
      runLen++;
    end
    if (mdioOut !== prevMdo && mdc === 1'b1) mdoBad++;
    prevMdc = mdc;
    prevMdo = mdioOut;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int idx, input logic [31:0] v);
    @(negedge clk);
    busWr = 1'b1; busAddr = 5'(idx * 4); busWrData = v;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input int idx, output logic [31:0] v);
    @(negedge clk);
    busRd = 1'b1; busAddr = 5'(idx * 4);
    @(negedge clk);
    busRd = 1'b0;
    v = busRdData;
  endtask

  task automatic waitReady(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rdReg(1, v);
      if (v[0]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] ctlWord(input logic [1:0] op, input logic [4:0] phy,
                                          input logic [4:0] rg, input bit go);
    return {op, 1'b0, phy, 3'b0, rg, 7'b0, go, 8'b0};
  endfunction

  task automatic xfer(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] dat, input int d);
    logic [31:0] v;
    logic [63:0] expF, mask;
    bit ok;
    wrReg(0, 32'h100 | 32'(d));
    if (op == 2'b01) wrReg(3, {16'b0, dat});
    else begin phyRdVal = dat; wrReg(3, {16'b0, ~dat}); end
    xferId++;
    wrReg(1, ctlWord(op, phy, rg, 1'b1));
    rdReg(1, v);
    chk("R3 ready drops after start", 64'(v[0]), 64'd0);
    chk("R3 start bit reads 0", 64'(v[8]), 64'd0);
    rdReg(4, v);
    chk("R8 accepted start clears flag", 64'(v[0]), 64'd0);
    waitReady(ok);
    chk("R3 ready returns", 64'(ok), 64'd1);
    rdReg(4, v);
    chk("R8 flag set at completion", 64'(v[0]), 64'd1);
    chk("R2 shortest MDC half period", 64'(minHalf), 64'(d + 1));
    chk("R2 longest MDC half period", 64'(maxHalf), 64'(d + 1));
    chk("R9 MDC low after frame", 64'(mdc), 64'd0);
    chk("R9 MDIO changed while MDC high", 64'(mdoBad), 64'd0);
    chk("R4 rising edges per frame", 64'(nRise), 64'd64);
    chk("R9 MDIO released when idle", 64'(mdioOe), 64'd0);
    if (op == 2'b01) begin
      expF = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, dat};
      chk("R4 write frame bits", gotFrame, expF);
      chk("R4 MDIO driven through write", gotOe, '1);
    end else begin
      expF = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 18'b0};
      mask = {{46{1'b1}}, 18'b0};
      chk("R5 read header bits", gotFrame & mask, expF);
      chk("R5 MDIO released from turnaround", gotOe, mask);
      rdReg(2, v);
      chk("R5 read result", 64'(v), 64'(dat));
    end
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    int dl [4] = '{0, 1, 2, 5};
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rdReg(i, v);
      chk("R1 register reset value", 64'(v), 64'd0);
    end
    chk("R1 MDC low after reset", 64'(mdc), 64'd0);
    chk("R1 MDIO not driven after reset", 64'(mdioOe), 64'd0);

    // R10 disabled controller ignores start
    wrReg(1, ctlWord(2'b01, 5'd1, 5'd2, 1'b1));
    rdReg(1, v);
    chk("R10 ready low while disabled", 64'(v[0]), 64'd0);
    repeat (20) @(negedge clk);
    chk("R10 no MDC while disabled", 64'(mdc), 64'd0);
    chk("R10 no MDIO drive while disabled", 64'(mdioOe), 64'd0);
    rdReg(4, v);
    chk("R10 flag untouched while disabled", 64'(v[0]), 64'd0);

    wrReg(0, 32'h102);
    rdReg(0, v);
    chk("R2 configuration readback", 64'(v), 64'h102);
    rdReg(1, v);
    chk("R3 ready when enabled and idle", 64'(v[0]), 64'd1);

    // R6 reserved opcodes
    for (int k = 0; k < 2; k++) begin
      wrReg(1, ctlWord(k == 0 ? 2'b00 : 2'b11, 5'd4, 5'd5, 1'b1));
      rdReg(1, v);
      chk("R6 ready stays with reserved opcode", 64'(v[0]), 64'd1);
      repeat (12) @(negedge clk);
      chk("R6 no MDC with reserved opcode", 64'(mdc), 64'd0);
      rdReg(4, v);
      chk("R6 flag untouched by reserved opcode", 64'(v[0]), 64'd0);
    end

    // divider and pattern sweep
    for (int di = 0; di < 4; di++) begin
      for (int i = 0; i < 4; i++) begin
        xfer(i[0] ? 2'b10 : 2'b01, 5'(dl[di] * 7 + i * 13), 5'(dl[di] * 3 + i * 5 + 1),
             16'(32'hA5C3 ^ (dl[di] * 4099 + i * 8257)), dl[di]);
      end
    end
    xfer(2'b01, 5'd31, 5'd31, 16'hFFFF, 1);
    xfer(2'b10, 5'd0, 5'd0, 16'h0000, 1);
    xfer(2'b10, 5'd31, 5'd31, 16'hFFFF, 0);
    xfer(2'b01, 5'd0, 5'd0, 16'h0000, 0);

    // R8 write-one-to-clear
    wrReg(4, 32'h0);
    rdReg(4, v);
    chk("R8 writing 0 keeps flag", 64'(v[0]), 64'd1);
    wrReg(4, 32'h1);
    rdReg(4, v);
    chk("R8 writing 1 clears flag", 64'(v[0]), 64'd0);

    // R7 start while busy is ignored
    wrReg(0, 32'h101);
    phyRdVal = 16'h1234;
    xferId++;
    wrReg(1, ctlWord(2'b10, 5'd3, 5'd4, 1'b1));
    repeat (20) @(negedge clk);
    wrReg(1, ctlWord(2'b01, 5'd9, 5'd10, 1'b1));
    rdReg(1, v);
    chk("R7 fields held while busy", 64'(v), 64'(ctlWord(2'b10, 5'd3, 5'd4, 1'b0)));
    waitReady(ok);
    chk("R7 first frame completes", 64'(ok), 64'd1);
    chk("R7 header of first frame kept", gotFrame & {{46{1'b1}}, 18'b0},
        {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd4, 18'b0});
    rdReg(2, v);
    chk("R7 read data of first frame", 64'(v), 64'h1234);

    // R1 registers writable to zero
    wrReg(2, 32'h0);
    rdReg(2, v);
    chk("R1 read result cleared", 64'(v), 64'd0);
    wrReg(3, 32'h0);
    rdReg(3, v);
    chk("R1 payload cleared", 64'(v), 64'd0);
    wrReg(0, 32'h0);
    rdReg(0, v);
    chk("R1 configuration cleared", 64'(v), 64'd0);
    rdReg(1, v);
    chk("R10 ready low after disable", 64'(v[0]), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk + 1, nFail + 1);
    $finish;
  end

endmodule